// File: doc/BRIEF.md
# Offset Calibration Sequencer for a Two-Channel Audio ADC

This block runs the power-up and reset sequence of the digital back end of a stereo 24-bit audio converter. It sits after the decimated sample stream. Its time base is a one-cycle frame strobe, one pulse per sample frame. While the reset input is low, the block holds the back end idle and raises its calibration-busy flag. When reset is released, the block counts frames. Inside a fixed power-of-two window of frames it sums the samples of each channel and keeps their mean as that channel's offset. It keeps the busy flag high for the full calibration length.

After calibration, every sample is corrected by subtracting its channel's stored offset. The result is clamped to the 24-bit two's-complement range. Corrected data reaches the outputs only after a second, longer frame count has elapsed. Until then the outputs stay at zero. Both counts double in double-rate mode and grow by one frame in slave timing. A select output tells the analog source mux what to feed the converter: during calibration it follows the calibration-source input, and afterwards it selects the analog inputs.

Top module: `ofs_cal_seq`

## Requirements
- R1: While `rst_n` is low, after at least one clock edge, `cal_busy` is 1, `data_valid` is 0, and both outputs are 0. The sequence starts again from frame 0 each time `rst_n` returns high.
- R2: Call the number of frame strobes seen since reset release the frame count. `cal_busy` stays 1 until the frame count reaches the calibration length, then drops and stays 0. The calibration length is CAL_FRAMES at normal rate (`dbl_rate`=0) and 2*CAL_FRAMES at double rate (`dbl_rate`=1).
- R3: `data_valid` rises when the frame count reaches the valid length, then stays 1 until reset. The valid length is VALID_FRAMES at normal rate and 2*VALID_FRAMES at double rate. `data_valid` is never 1 while `cal_busy` is 1.
- R4: With `slave_mode`=1, both the calibration length and the valid length are one frame longer.
- R5: `dbl_rate` and `slave_mode` are captured on each clock while `rst_n` is low. Changing them after release has no effect on either length.
- R6: `src_sel_input` equals `cal_src_in` while `cal_busy` is 1, and equals 1 (analog inputs selected) once `cal_busy` is 0. A value of 0 selects the internal common-mode source.
- R7: The offset of each channel is the sum of its samples at 0-based frame indices WIN_START to WIN_START+2^AVG_LOG2-1, arithmetically shifted right by AVG_LOG2 (floor of the mean). Each channel's offset is independent of the other channel, and each is cleared by reset.
- R8: A sample strobed at frame index k, with k at or past the valid length, appears on its output one clock after the strobe as the sample minus the offset. The outputs hold their value between strobes.
- R9: Corrected results above 0x7FFFFF clamp to 0x7FFFFF. Results below -0x800000 clamp to 0x800000.
- R10: Samples strobed before the frame count reaches the valid length produce an output of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; releasing it starts calibration |
| frame_stb | input | 1 | One-cycle pulse per sample frame; the samples are taken on it |
| dbl_rate | input | 1 | 1 = double-rate mode (captured during reset) |
| slave_mode | input | 1 | 1 = slave timing, adds one frame (captured during reset) |
| cal_src_in | input | 1 | Calibration source request: 1 analog inputs, 0 common-mode |
| smp_l | input | SMP_W | Left sample, two's complement |
| smp_r | input | SMP_W | Right sample, two's complement |
| cal_busy | output | 1 | Calibration in progress |
| data_valid | output | 1 | Corrected data is on the outputs |
| src_sel_input | output | 1 | Select toward the analog mux: 1 analog inputs, 0 common-mode |
| out_l | output | SMP_W | Corrected, clamped left sample |
| out_r | output | SMP_W | Corrected, clamped right sample |

## Verification
The bench runs the sequence in all four rate and timing combinations. It counts the strobes seen while busy, and the strobes seen before valid, and compares both counts with the lengths. A design that forgot to double, or to add the slave frame, would be off by exactly CAL_FRAMES or by one. Samples are a DC level plus a ramp with a different slope on each channel, so a swapped, shared or unfloored mean shows as a constant error on the corrected ramp. A reset in the middle of the averaging window followed by a new run with another DC level catches an accumulator that is not cleared. Full-scale samples against offsets of opposite sign catch wraparound instead of clamping, and flipping the mode inputs after release catches a design that does not latch them.

// File: rtl/ofs_cal_pkg.sv
// Shared definitions for the offset calibration sequencer.
// Assumes: two channels, the left channel at index 0.
package ofs_cal_pkg;
    localparam int NCH = 2;

    // Operating mode as captured during reset
    typedef struct packed {
        logic dbl;  // double-rate frame counts
        logic slv;  // slave timing, one extra frame
    } mode_t;
endpackage

// File: rtl/cal_frame_ctr.sv
// Frame counter and phase decoder.
// Counts frame strobes after reset release. Drives the busy and valid
// levels and the averaging-window enable.
// Assumes: the mode inputs are stable during reset; WIN_START+2^AVG_LOG2
// is no larger than CAL_FRAMES, and CAL_FRAMES is no larger than VALID_FRAMES.
module cal_frame_ctr
    import ofs_cal_pkg::*;
#(
    parameter int CAL_FRAMES   = 8704,
    parameter int VALID_FRAMES = 8960,
    parameter int WIN_START    = 256,
    parameter int AVG_LOG2     = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic dbl_in,
    input  logic slv_in,
    output logic busy,
    output logic valid,
    output logic win_en
);
    localparam int CNT_W = $clog2(2 * VALID_FRAMES + 2) + 1;
    localparam logic [CNT_W-1:0] CAL_BASE = CNT_W'(CAL_FRAMES);
    localparam logic [CNT_W-1:0] VAL_BASE = CNT_W'(VALID_FRAMES);
    localparam logic [CNT_W-1:0] WIN_LO   = CNT_W'(WIN_START);
    localparam logic [CNT_W-1:0] WIN_HI   = CNT_W'(WIN_START + (1 << AVG_LOG2));

    mode_t            mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cal_len;
    logic [CNT_W-1:0] val_len;

    // Lengths for the captured mode
    always_comb begin
        cal_len = (mode_q.dbl ? (CAL_BASE << 1) : CAL_BASE) + CNT_W'(mode_q.slv);
        val_len = (mode_q.dbl ? (VAL_BASE << 1) : VAL_BASE) + CNT_W'(mode_q.slv);
    end

    // Capture the mode during reset; count frames after release up to the valid length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '{dbl: dbl_in, slv: slv_in};
            cnt_q  <= '0;
        end else if (frame_stb && (cnt_q < val_len)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Phase decode from the registered count
    assign busy   = (cnt_q < cal_len);
    assign valid  = (cnt_q >= val_len);
    assign win_en = frame_stb && rst_n && (cnt_q >= WIN_LO) && (cnt_q < WIN_HI);
endmodule

// File: rtl/chan_offset_acc.sv
// Offset accumulator for one channel.
// Sums the samples strobed inside the window at extended width. The
// offset is the sum shifted right arithmetically by AVG_LOG2.
// Assumes: win_en is high for exactly 2^AVG_LOG2 strobes per sequence.
module chan_offset_acc #(
    parameter int SMP_W    = 24,
    parameter int AVG_LOG2 = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    win_en,
    input  logic signed [SMP_W-1:0] smp,
    output logic signed [SMP_W-1:0] offset
);
    localparam int ACC_W = SMP_W + AVG_LOG2;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] mean_full;

    // Clear on reset; add each windowed sample, sign-extended
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (win_en) begin
            acc_q <= acc_q + ACC_W'(smp);
        end
    end

    // Floor of the mean; it fits in SMP_W once the window is complete
    assign mean_full = acc_q >>> AVG_LOG2;
    assign offset    = mean_full[SMP_W-1:0];
endmodule

// File: rtl/chan_correct.sv
// Output stage for one channel: subtracts the offset, clamps the result,
// and forces it to zero until data is valid. It updates only on a strobe.
module chan_correct #(
    parameter int SMP_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_stb,
    input  logic                    valid,
    input  logic signed [SMP_W-1:0] smp,
    input  logic signed [SMP_W-1:0] offset,
    output logic signed [SMP_W-1:0] y
);
    localparam logic signed [SMP_W-1:0] POS_FS = {1'b0, {(SMP_W-1){1'b1}}};
    localparam logic signed [SMP_W-1:0] NEG_FS = {1'b1, {(SMP_W-1){1'b0}}};

    logic signed [SMP_W:0]   diff;
    logic signed [SMP_W-1:0] clamped;

    // One-bit-wider difference, then clamp when the two top bits disagree
    always_comb begin
        diff = {smp[SMP_W-1], smp} - {offset[SMP_W-1], offset};
        if (diff[SMP_W] != diff[SMP_W-1]) begin
            clamped = diff[SMP_W] ? NEG_FS : POS_FS;
        end else begin
            clamped = diff[SMP_W-1:0];
        end
    end

    // Register the result per strobe; zero until valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y <= '0;
        end else if (frame_stb) begin
            y <= valid ? clamped : '0;
        end
    end
endmodule

// File: rtl/ofs_cal_seq.sv
// Top of the offset calibration sequencer.
// One shared frame counter drives per-channel accumulators and output
// stages, built by a generate loop over the channels.
// Assumes: frame_stb is a single-cycle pulse; the samples are valid on it.
module ofs_cal_seq
    import ofs_cal_pkg::*;
#(
    parameter int SMP_W        = 24,
    parameter int CAL_FRAMES   = 8704,
    parameter int VALID_FRAMES = 8960,
    parameter int WIN_START    = 256,
    parameter int AVG_LOG2     = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_stb,
    input  logic                    dbl_rate,
    input  logic                    slave_mode,
    input  logic                    cal_src_in,
    input  logic signed [SMP_W-1:0] smp_l,
    input  logic signed [SMP_W-1:0] smp_r,
    output logic                    cal_busy,
    output logic                    data_valid,
    output logic                    src_sel_input,
    output logic signed [SMP_W-1:0] out_l,
    output logic signed [SMP_W-1:0] out_r
);
    logic busy;
    logic valid;
    logic win_en;
    logic signed [SMP_W-1:0] smp_a [NCH];
    logic signed [SMP_W-1:0] ofs_a [NCH];
    logic signed [SMP_W-1:0] y_a   [NCH];

    cal_frame_ctr #(
        .CAL_FRAMES  (CAL_FRAMES),
        .VALID_FRAMES(VALID_FRAMES),
        .WIN_START   (WIN_START),
        .AVG_LOG2    (AVG_LOG2)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_stb(frame_stb),
        .dbl_in   (dbl_rate),
        .slv_in   (slave_mode),
        .busy     (busy),
        .valid    (valid),
        .win_en   (win_en)
    );

    assign smp_a[0] = smp_l;
    assign smp_a[1] = smp_r;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chan_offset_acc #(.SMP_W(SMP_W), .AVG_LOG2(AVG_LOG2)) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .win_en(win_en),
            .smp   (smp_a[c]),
            .offset(ofs_a[c])
        );
        chan_correct #(.SMP_W(SMP_W)) u_cor (
            .clk      (clk),
            .rst_n    (rst_n),
            .frame_stb(frame_stb),
            .valid    (valid),
            .smp      (smp_a[c]),
            .offset   (ofs_a[c]),
            .y        (y_a[c])
        );
    end

    assign out_l         = y_a[0];
    assign out_r         = y_a[1];
    assign cal_busy      = busy;
    assign data_valid    = valid;
    // Source select: the requested source during calibration, analog inputs afterwards
    assign src_sel_input = busy ? cal_src_in : 1'b1;
endmodule

// File: rtl/ofs_cal_seq_chk.sv
// Assertion checker for ofs_cal_seq, attached with a bind statement.
module ofs_cal_seq_chk #(
    parameter int SMP_W = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    frame_stb,
    input logic                    cal_busy,
    input logic                    data_valid,
    input logic                    src_sel_input,
    input logic signed [SMP_W-1:0] out_l,
    input logic signed [SMP_W-1:0] out_r
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (cal_busy && !data_valid && out_l == '0 && out_r == '0)); // R1

    AST_BUSY_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_busy |=> !cal_busy); // R2

    AST_BUSY_DROPS_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_busy) |-> $past(frame_stb)); // R2

    AST_VALID_AFTER_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> !cal_busy); // R3

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> data_valid); // R3

    AST_SEL_AFTER_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_busy |-> src_sel_input); // R6

    AST_HOLD_BETWEEN_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> ($stable(out_l) && $stable(out_r))); // R8

    AST_ZERO_UNTIL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid |-> (out_l == '0 && out_r == '0)); // R10
endmodule

bind ofs_cal_seq ofs_cal_seq_chk #(.SMP_W(SMP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_stb    (frame_stb),
    .cal_busy     (cal_busy),
    .data_valid   (data_valid),
    .src_sel_input(src_sel_input),
    .out_l        (out_l),
    .out_r        (out_r)
);

// File: tb/ofs_cal_seq_test.sv
// Bench: a behavioural model compared on every clock, plus directed checks
// on the frame counts, the ramp correction and the clamping.
module ofs_cal_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int SW   = 24;
    localparam int CALF = 40;
    localparam int VALF = 48;
    localparam int WS   = 8;
    localparam int AL   = 3;
    localparam int WN   = 1 << AL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_stb = 1'b0;
    logic dbl_rate = 1'b0;
    logic slave_mode = 1'b0;
    logic cal_src_in = 1'b0;
    logic signed [SW-1:0] smp_l = '0;
    logic signed [SW-1:0] smp_r = '0;
    logic cal_busy, data_valid, src_sel_input;
    logic signed [SW-1:0] out_l, out_r;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ofs_cal_seq #(
        .SMP_W(SW), .CAL_FRAMES(CALF), .VALID_FRAMES(VALF),
        .WIN_START(WS), .AVG_LOG2(AL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .dbl_rate(dbl_rate),
        .slave_mode(slave_mode), .cal_src_in(cal_src_in), .smp_l(smp_l), .smp_r(smp_r),
        .cal_busy(cal_busy), .data_valid(data_valid), .src_sel_input(src_sel_input),
        .out_l(out_l), .out_r(out_r)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic longint clamp(input longint v);
        if (v > 8388607) return 8388607;
        if (v < -8388608) return -8388608;
        return v;
    endfunction

    // Reference model: frame count, captured mode, window sums, expected outputs
    int     m_cnt = 0;
    bit     m_dbl, m_slv, m_ready = 1'b0;
    longint sum_l, sum_r, m_yl, m_yr;

    function automatic int clen_f();  return (m_dbl ? 2*CALF : CALF) + int'(m_slv); endfunction
    function automatic int vlen_f();  return (m_dbl ? 2*VALF : VALF) + int'(m_slv); endfunction

    always @(posedge clk) begin
        m_ready = 1'b1;
        if (!rst_n) begin
            m_cnt = 0; m_dbl = dbl_rate; m_slv = slave_mode;
            sum_l = 0; sum_r = 0; m_yl = 0; m_yr = 0;
        end else if (frame_stb) begin
            if (m_cnt >= WS && m_cnt < WS + WN) begin
                sum_l += longint'(smp_l);
                sum_r += longint'(smp_r);
            end
            if (m_cnt >= vlen_f()) begin
                m_yl = clamp(longint'(smp_l) - (sum_l >>> AL));
                m_yr = clamp(longint'(smp_r) - (sum_r >>> AL));
            end else begin
                m_yl = 0; m_yr = 0;
            end
            if (m_cnt < vlen_f()) m_cnt++;
        end
    end

    // Per-cycle comparison, a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (m_ready && !done) begin
            chk("R1/R2/R4 cal_busy", cal_busy, (m_cnt < clen_f()));
            chk("R3/R4/R5 data_valid", data_valid, (m_cnt >= vlen_f()));
            chk("R6 src_sel_input", src_sel_input, (m_cnt < clen_f()) ? cal_src_in : 1'b1);
            chk("R7/R8/R9/R10 out_l", out_l, m_yl);
            chk("R7/R8/R9/R10 out_r", out_r, m_yr);
        end
    end

    // One sequence: reset, release, nfr frames of DC plus ramp
    task automatic run(input bit dbl, input bit slv, input int dcl, input int dcr,
                       input int nfr, input bit full);
        int clen, vlen, busy_fr, first_valid;
        clen = (dbl ? 2*CALF : CALF) + int'(slv);
        vlen = (dbl ? 2*VALF : VALF) + int'(slv);
        busy_fr = 0; first_valid = -1;
        @(negedge clk);
        rst_n = 1'b0; dbl_rate = dbl; slave_mode = slv; frame_stb = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", cal_busy, 1);
        chk("R1 valid in reset", data_valid, 0);
        chk("R1 out_l in reset", out_l, 0);
        rst_n = 1'b1;
        dbl_rate = ~dbl; slave_mode = ~slv; // r5_ mode change after release
        for (int k = 0; k < nfr; k++) begin
            if (cal_busy) busy_fr++;
            if (data_valid && first_valid < 0) first_valid = k;
            cal_src_in = k[1];
            frame_stb = 1'b1;
            if (k == vlen + 3) begin
                smp_l = 24'sh7FFFFF; smp_r = 24'sh800000;
            end else begin
                smp_l = SW'(dcl + k); smp_r = SW'(dcr - 2*k);
            end
            @(negedge clk);
            frame_stb = 1'b0;
            if (full && k == vlen + 1) begin
                chk("R7/R8 ramp left", out_l, k - 11);
                chk("R7/R8 ramp right", out_r, 23 - 2*k);
            end
            if (full && k == vlen + 3) begin
                chk("R9 clamp positive", out_l, 8388607);
                chk("R9 clamp negative", out_r, -8388608);
            end
            if (full && k == vlen - 1) chk("R10 zero before valid", out_l, 0);
            @(negedge clk);
            if (full && k == vlen + 1) chk("R8 hold", out_l, k - 11);
        end
        if (full) begin
            chk("R2/R4 busy frame count", busy_fr, clen);
            chk("R3/R4 first valid frame", first_valid, vlen);
        end
    endtask

    initial begin
        run(1'b0, 1'b0, -1000, 5000, VALF + 8, 1'b1);
        run(1'b1, 1'b0, -1000, 5000, 2*VALF + 8, 1'b1);
        run(1'b0, 1'b1, -1000, 5000, VALF + 9, 1'b1);
        run(1'b0, 1'b0, 77777, -3333, WS + 3, 1'b0);   // R1 abort inside the window
        run(1'b1, 1'b1, -1000, 5000, 2*VALF + 9, 1'b1);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule